// File: doc/BRIEF.md
# PHY Power Sequencer with Rollback

This block raises and lowers the clocks, resets and optional bus-power supply of a serial PHY in a fixed order. The work is split into two phases. The link phase enables the link clock and an auxiliary clock, then releases the link reset and the auxiliary reset. The PHY phase enables an external reference clock and the PHY clock, releases the PHY reset, and finally switches on bus power. Each bring-up step changes one output and then waits for the resource to answer on a shared acknowledge or failure input. Teardown steps take one cycle each and do not wait for an answer.

If a bring-up step fails, or no answer arrives within `STEP_TIMEOUT` cycles, the failed resource is dropped again at once. The steps already completed in that phase are then undone one per cycle in the reverse order, and the status shows an error. Requests that arrive while a sequence is running are held and served once it ends. Requests that do not fit the current level are discarded. The lines that generate the clocks and control the regulators are outside this block. They answer through `step_ack` and `step_fail`.

Top module: `phy_pwr_seq`

## Requirements
- R1: During and right after reset, all clock enables and `vbus_en` are 0, all `*_rst_n` outputs are 0 (reset asserted), `busy` is 0 and `status` is 0 (idle).
- R2: An init request at level none raises, in this order, `link_clk_en`, `aux_clk_en`, `link_rst_n`, `aux_rst_n`. Each one rises only after the previous step is acknowledged. The sequence ends with `status` = 1 (initialized).
- R3: An exit request at level initialized lowers `aux_rst_n`, `link_rst_n`, `aux_clk_en` and `link_clk_en` in that order, one per cycle, and ends with `status` = 0.
- R4: A power-on request at level initialized raises `ext_clk_en`, `phy_clk_en`, `phy_rst_n` and `vbus_en` in that order, each after the previous acknowledge. It ends with `status` = 2 (powered).
- R5: A power-off request at level powered lowers `vbus_en` (only if it is high), `phy_rst_n`, `phy_clk_en` and `ext_clk_en` in that order, and ends with `status` = 1.
- R6: If `vbus_present` is 0 when the bus-power step is reached, that step is skipped. `vbus_en` stays 0 and power-on completes without error.
- R7: A step that sees `step_fail` (which takes priority over `step_ack`) has its line dropped in the next edge. Completed steps of the same phase are then undone in reverse order. The other phase is left untouched, and the block returns to not busy with `status` = 3 (error).
- R8: A step that gets no acknowledge fails exactly `STEP_TIMEOUT` cycles after its line changed. An acknowledge in that last cycle still counts.
- R9: A request that arrives while busy is held and served when the running sequence ends. A request that is not legal for the current level is discarded with no output change. The legal requests are: init at level none, power-on and exit at level initialized, and power-off at level powered. When several legal requests are pending, the order is init, power-on, power-off, exit.
- R10: The error status stays until the next accepted request starts. The level reached after a rollback (none or initialized) still decides which requests are legal.
- R11: At most one controlled line changes per cycle. Taken in bit order (link clock, aux clock, link reset, aux reset, ext clock, PHY clock, PHY reset, bus power), the active lines always form a contiguous run starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Pulse: start the link phase |
| exit_req | input | 1 | Pulse: tear down the link phase |
| pwron_req | input | 1 | Pulse: start the PHY phase |
| pwroff_req | input | 1 | Pulse: tear down the PHY phase |
| vbus_present | input | 1 | A bus-power supply is fitted |
| step_ack | input | 1 | Current bring-up step succeeded |
| step_fail | input | 1 | Current bring-up step failed |
| link_clk_en | output | 1 | Link clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| link_rst_n | output | 1 | Link reset, low = asserted |
| aux_rst_n | output | 1 | Auxiliary reset, low = asserted |
| ext_clk_en | output | 1 | External reference clock enable |
| phy_clk_en | output | 1 | PHY clock enable |
| phy_rst_n | output | 1 | PHY reset, low = asserted |
| vbus_en | output | 1 | Bus-power enable |
| busy | output | 1 | A sequence is running |
| status | output | 2 | 0 idle, 1 initialized, 2 powered, 3 error |

## Verification
The hardest state to reach is a rollback that starts from the middle of a phase. It needs several steps acknowledged and then one step refused or left unanswered. The bench uses a responder that watches the controlled lines and answers each rising line a few cycles later. It can refuse a chosen step or stay silent on it. Every line change is logged with its cycle number, so the unwind order and the exact timeout distance can be compared with the expected lists. Held requests are produced by pulsing power-on and exit while the link phase is still being acknowledged.

// File: rtl/pps_pkg.sv
// Shared constants and types for the PHY power sequencer.
// Assumes eight controlled lines: four for the link phase (bits 0..3) and
// four for the PHY phase (bits 4..7); bit order is also bring-up order.
package pps_pkg;
    localparam int NUM_STEPS  = 8;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int NUM_RQ     = 4;

    // Request slots; lower index wins when several are pending.
    localparam int RQ_INIT    = 0;
    localparam int RQ_PWRON   = 1;
    localparam int RQ_PWROFF  = 2;
    localparam int RQ_EXIT    = 3;

    localparam logic [STEP_W-1:0] LINK_FIRST = 3'd0;
    localparam logic [STEP_W-1:0] LINK_LAST  = 3'd3;
    localparam logic [STEP_W-1:0] PHY_FIRST  = 3'd4;
    localparam logic [STEP_W-1:0] PHY_LAST   = 3'd7;
    localparam logic [STEP_W-1:0] VBUS_STEP  = 3'd7;

    typedef enum logic [1:0] {
        PST_IDLE    = 2'd0,
        PST_INIT    = 2'd1,
        PST_POWERED = 2'd2,
        PST_ERROR   = 2'd3
    } pps_status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_UP   = 2'd1,
        S_DOWN = 2'd2
    } pps_state_e;
endpackage

// File: rtl/pps_req_hold.sv
// Request holding register: keeps every request pulse until the sequencer
// clears it. Assumes requests are single-cycle pulses; a pulse and a clear
// of the same slot in one cycle leave the slot empty.
module pps_req_hold #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clear_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    // Pending view includes requests arriving in this very cycle.
    assign pend_o = pend_q | req_i;

    // Accumulate new pulses and drop the slots the sequencer consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | req_i) & ~clear_i;
    end

    // R9: a cleared slot never survives to the next cycle unless re-requested.
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clear_i & ~req_i)) |=> ((pend_q & $past(clear_i & ~req_i)) == '0));
endmodule

// File: rtl/pps_step_timer.sv
// Step watchdog: counts cycles while a bring-up step waits and flags the
// cycle in which the LIMIT-th edge since the step began will occur.
// Assumes clr_i is high whenever no step is waiting or a step just ended.
module pps_step_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    // Count waiting cycles; restart on every new step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + 1'b1;
    end

    // R8: the counter never runs past the limit while a step waits.
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/phy_pwr_seq.sv
// PHY power sequencer. Raises the link phase and the PHY phase one line at a
// time, waits for step_ack / step_fail / timeout after each raise, tears down
// in reverse order one line per cycle, and rolls back a phase on failure.
// Assumes step_ack and step_fail refer to the line raised most recently.
module phy_pwr_seq
    import pps_pkg::*;
#(
    parameter int STEP_TIMEOUT = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_req,
    input  logic       exit_req,
    input  logic       pwron_req,
    input  logic       pwroff_req,
    input  logic       vbus_present,
    input  logic       step_ack,
    input  logic       step_fail,
    output logic       link_clk_en,
    output logic       aux_clk_en,
    output logic       link_rst_n,
    output logic       aux_rst_n,
    output logic       ext_clk_en,
    output logic       phy_clk_en,
    output logic       phy_rst_n,
    output logic       vbus_en,
    output logic       busy,
    output logic [1:0] status
);
    pps_state_e            state_q;
    logic [STEP_W-1:0]     cur_q, lim_q, nxt;
    logic [1:0]            lvl_q;
    logic                  err_q;
    logic [NUM_STEPS-1:0]  on_q;
    logic [NUM_RQ-1:0]     req_vec, pend, legal, cand, pick, clr_mask;
    logic                  tmo_exp, fail_now, ok_now, t_clr, t_run;

    assign req_vec = {exit_req, pwroff_req, pwron_req, init_req};

    pps_req_hold #(.N(NUM_RQ)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_vec),
        .clear_i (clr_mask),
        .pend_o  (pend)
    );

    // Which requests fit the current level (0 none, 1 link up, 2 all up).
    always_comb begin
        legal            = '0;
        legal[RQ_INIT]   = (lvl_q == 2'd0);
        legal[RQ_PWRON]  = (lvl_q == 2'd1);
        legal[RQ_EXIT]   = (lvl_q == 2'd1);
        legal[RQ_PWROFF] = (lvl_q == 2'd2);
    end

    // Pick the lowest-index legal request; drop illegal ones when idle.
    assign cand     = pend & legal;
    assign pick     = (state_q == S_IDLE) ? (cand & (~cand + 1'b1)) : '0;
    assign clr_mask = (state_q == S_IDLE) ? ((pend & ~legal) | pick) : '0;

    assign t_run = (state_q == S_UP);
    assign t_clr = !t_run || step_ack || step_fail;

    pps_step_timer #(.LIMIT(STEP_TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (t_clr),
        .run_i     (t_run),
        .expired_o (tmo_exp)
    );

    assign fail_now = step_fail || (tmo_exp && !step_ack);
    assign ok_now   = step_ack && !step_fail;
    assign nxt      = cur_q + 1'b1;

    // Main sequencer: start, advance, fail/rollback and teardown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            lim_q   <= '0;
            lvl_q   <= 2'd0;
            err_q   <= 1'b0;
            on_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (pick[RQ_INIT]) begin
                        state_q           <= S_UP;
                        cur_q             <= LINK_FIRST;
                        lim_q             <= LINK_LAST;
                        on_q[LINK_FIRST]  <= 1'b1;
                        err_q             <= 1'b0;
                    end else if (pick[RQ_PWRON]) begin
                        state_q           <= S_UP;
                        cur_q             <= PHY_FIRST;
                        lim_q             <= PHY_LAST;
                        on_q[PHY_FIRST]   <= 1'b1;
                        err_q             <= 1'b0;
                    end else if (pick[RQ_PWROFF]) begin
                        state_q           <= S_DOWN;
                        cur_q             <= PHY_LAST;
                        lim_q             <= PHY_FIRST;
                        err_q             <= 1'b0;
                    end else if (pick[RQ_EXIT]) begin
                        state_q           <= S_DOWN;
                        cur_q             <= LINK_LAST;
                        lim_q             <= LINK_FIRST;
                        err_q             <= 1'b0;
                    end
                end
                S_UP: begin
                    if (fail_now) begin
                        on_q[cur_q] <= 1'b0;
                        err_q       <= 1'b1;
                        if (cur_q[1:0] == 2'd0) begin
                            state_q <= S_IDLE;
                        end else begin
                            state_q <= S_DOWN;
                            cur_q   <= cur_q - 1'b1;
                            lim_q   <= {cur_q[2], 2'b00};
                        end
                    end else if (ok_now) begin
                        if (cur_q == lim_q || (nxt == VBUS_STEP && !vbus_present)) begin
                            state_q <= S_IDLE;
                            lvl_q   <= lvl_q + 2'd1;
                        end else begin
                            cur_q     <= nxt;
                            on_q[nxt] <= 1'b1;
                        end
                    end
                end
                S_DOWN: begin
                    on_q[cur_q] <= 1'b0;
                    if (cur_q == lim_q) begin
                        state_q <= S_IDLE;
                        if (!err_q) lvl_q <= lvl_q - 2'd1;
                    end else begin
                        cur_q <= cur_q - 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the named lines from the step vector.
    assign link_clk_en = on_q[0];
    assign aux_clk_en  = on_q[1];
    assign link_rst_n  = on_q[2];
    assign aux_rst_n   = on_q[3];
    assign ext_clk_en  = on_q[4];
    assign phy_clk_en  = on_q[5];
    assign phy_rst_n   = on_q[6];
    assign vbus_en     = on_q[7];
    assign busy        = (state_q != S_IDLE);
    assign status      = err_q ? PST_ERROR : lvl_q;

    // R11: never more than one controlled line moves per cycle.
    a_r11_one_change: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(on_q ^ $past(on_q)) <= 1);

    // R11: active lines always form a contiguous run from bit 0.
    a_r11_thermo: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q & (on_q + 1'b1)) == '0);

    // R9: while idle across two edges no line moves.
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(on_q));

    // R6: bus power only rises when a supply was reported.
    a_r6_vbus_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q[7]) |-> $past(vbus_present));

    // R7: after a rollback settles, a phase is either fully up or fully down.
    a_r7_settled_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && status == PST_ERROR) |-> (on_q == 8'h00 || on_q == 8'h0F));
endmodule

// File: tb/phy_pwr_seq_tb.sv
module phy_pwr_seq_tb;
    localparam int TMO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 0, exit_req = 0, pwron_req = 0, pwroff_req = 0;
    logic vbus_present = 1'b1;
    logic step_ack = 0, step_fail = 0;
    logic link_clk_en, aux_clk_en, link_rst_n, aux_rst_n;
    logic ext_clk_en, phy_clk_en, phy_rst_n, vbus_en, busy;
    logic [1:0] status;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    phy_pwr_seq #(.STEP_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .init_req(init_req), .exit_req(exit_req),
        .pwron_req(pwron_req), .pwroff_req(pwroff_req),
        .vbus_present(vbus_present),
        .step_ack(step_ack), .step_fail(step_fail),
        .link_clk_en(link_clk_en), .aux_clk_en(aux_clk_en),
        .link_rst_n(link_rst_n), .aux_rst_n(aux_rst_n),
        .ext_clk_en(ext_clk_en), .phy_clk_en(phy_clk_en),
        .phy_rst_n(phy_rst_n), .vbus_en(vbus_en),
        .busy(busy), .status(status)
    );

    always #4 clk = ~clk;   // 125 MHz

    logic [7:0] lines;
    assign lines = {vbus_en, phy_rst_n, phy_clk_en, ext_clk_en,
                    aux_rst_n, link_rst_n, aux_clk_en, link_clk_en};

    // Change log and responder state.
    logic [3:0] lg_code [0:31];
    int         lg_cyc  [0:31];
    int         lg_n = 0;
    logic [7:0] prev = 8'h00;
    logic [7:0] fail_mask = 8'h00;
    logic [7:0] mute_mask = 8'h00;
    int         cd = -1;
    int         cidx = 0;
    logic       r11_bad = 1'b0;

    // Log every line change, check R11 shape, answer each raised line.
    always @(negedge clk) begin
        cyc = cyc + 1;
        step_ack  = 1'b0;
        step_fail = 1'b0;
        if (rst_n) begin
            if (cd > 0) cd = cd - 1;
            else if (cd == 0) begin
                if (fail_mask[cidx]) step_fail = 1'b1;
                else                 step_ack  = 1'b1;
                cd = -1;
            end
            if ($countones(lines ^ prev) > 1) r11_bad = 1'b1;
            if ((lines & (lines + 8'd1)) != 8'h00) r11_bad = 1'b1;
            for (int k = 0; k < 8; k++) begin
                if (lines[k] != prev[k]) begin
                    if (lg_n < 32) begin
                        lg_code[lg_n] = {lines[k], 3'(k)};
                        lg_cyc[lg_n]  = cyc;
                        lg_n = lg_n + 1;
                    end
                    if (lines[k]) begin
                        cidx = k;
                        cd = mute_mask[k] ? -1 : 2;
                    end
                end
            end
        end
        prev = lines;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        wait (cyc > 100000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Compare the change log with a list of {up,idx} nibbles, first in LSBs.
    task automatic chk_log(input string req, input int n, input logic [63:0] codes);
        logic [63:0] got = '0;
        for (int i = 0; i < lg_n && i < 16; i++) got[i*4 +: 4] = lg_code[i];
        chk({req, " log length"}, lg_n, n);
        chk({req, " log order"}, int'(got[31:0]), int'(codes[31:0]));
    endtask

    task automatic pulse(input int which);
        lg_n = 0;
        @(negedge clk);
        case (which)
            0: init_req   = 1'b1;
            1: pwron_req  = 1'b1;
            2: pwroff_req = 1'b1;
            default: exit_req = 1'b1;
        endcase
        @(negedge clk);
        init_req = 0; pwron_req = 0; pwroff_req = 0; exit_req = 0;
    endtask

    // Wait until busy has been low for three consecutive samples.
    task automatic settle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 lines in reset", lines, 8'h00);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lines after reset", lines, 8'h00);
        chk("R1 status after reset", status, 0);
    endtask

    task automatic t_illegal_at_none();
        pulse(1); settle();
        chk("R9 power-on at level none dropped", lines, 8'h00);
        chk("R9 no log for dropped request", lg_n, 0);
    endtask

    task automatic t_init_fail();
        fail_mask = 8'h04;
        pulse(0); settle();
        fail_mask = 8'h00;
        chk_log("R7 init fail at step 2", 6, 64'h012A98);
        chk("R7 lines after init rollback", lines, 8'h00);
        chk("R7 status error", status, 3);
    endtask

    task automatic t_init_timeout();
        mute_mask = 8'h02;
        pulse(0); settle();
        mute_mask = 8'h00;
        chk_log("R8 timeout at step 1", 4, 64'h0198);
        chk("R8 timeout distance", lg_cyc[2] - lg_cyc[1], TMO);
        chk("R10 still error after timeout", status, 3);
    endtask

    task automatic t_init_ok();
        pulse(0); settle();
        chk_log("R2 init order", 4, 64'hBA98);
        chk("R10 error cleared by init", status, 1);
        chk("R2 lines after init", lines, 8'h0F);
    endtask

    task automatic t_pwron_fail();
        fail_mask = 8'h40;
        pulse(1); settle();
        fail_mask = 8'h00;
        chk_log("R7 power-on fail at step 6", 6, 64'h456EDC);
        chk("R7 link phase untouched", lines, 8'h0F);
        chk("R7 status error", status, 3);
    endtask

    task automatic t_pwron_ok();
        pulse(1); settle();
        chk_log("R4 power-on order", 4, 64'hFEDC);
        chk("R4 status powered", status, 2);
    endtask

    task automatic t_exit_while_powered();
        pulse(3); settle();
        chk("R9 exit while powered dropped", lines, 8'hFF);
        chk("R9 status kept", status, 2);
    endtask

    task automatic t_pwroff();
        pulse(2); settle();
        chk_log("R5 power-off order", 4, 64'h4567);
        chk("R5 status initialized", status, 1);
    endtask

    task automatic t_no_vbus();
        vbus_present = 1'b0;
        pulse(1); settle();
        chk_log("R6 bus-power step skipped", 3, 64'hEDC);
        chk("R6 status powered", status, 2);
        chk("R6 vbus_en low", vbus_en, 0);
        pulse(2); settle();
        chk_log("R5 power-off without supply", 3, 64'h456);
        vbus_present = 1'b1;
    endtask

    task automatic t_exit();
        pulse(3); settle();
        chk_log("R3 exit order", 4, 64'h0123);
        chk("R3 status idle", status, 0);
    endtask

    task automatic t_first_step_fail();
        fail_mask = 8'h01;
        pulse(0); settle();
        fail_mask = 8'h00;
        chk_log("R7 fail at first step", 2, 64'h08);
        chk("R7 status error", status, 3);
    endtask

    task automatic t_held();
        lg_n = 0;
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        @(negedge clk);
        chk("R9 busy during init", busy, 1);
        pwron_req = 1'b1; exit_req = 1'b1;
        @(negedge clk); pwron_req = 1'b0; exit_req = 1'b0;
        settle();
        chk_log("R9 held power-on after init", 8, 64'hFEDCBA98);
        chk("R9 exit dropped once powered", status, 2);
    endtask

    initial begin
        t_reset();
        t_illegal_at_none();
        t_init_fail();
        t_init_timeout();
        t_init_ok();
        t_pwron_fail();
        t_pwron_ok();
        t_exit_while_powered();
        t_pwroff();
        t_no_vbus();
        t_exit();
        t_first_step_fail();
        t_held();
        chk("R11 one-step contiguous lines", r11_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule